// File: doc/BRIEF.md
# Companding Encoder Conversion Sequencer

This block is the digital sequencer of a charge-redistribution companding encoder. It works against an analog array made of a binary-weighted capacitor bank and a 32-tap resistor string, and it reads one comparator. Each frame strobe starts one conversion. The input is first held on the array while every lower plate sits at the reference. The polarity is then decided. After that, a one-capacitor-at-a-time chord search runs in a direction set by the polarity, and a four-bit binary search finds the step inside the chord. The result is an 8-bit sign/chord/step word and a one-cycle done pulse.

The whole conversion uses a single reference polarity. A positive input is referred to ground by moving all plates to ground, and the chord search then raises plates to the reference. A negative input keeps the plates at the reference, and the search drops them to ground. The comparator is read relative to the sign: during the chord and step phases, the input counts as beyond the trial level when the comparator output equals the sign bit. Inside the lowest chord, the tap index has one added to it. This gives the half-step offset next to the origin.

Top module: `compand_enc_seq`

## Requirements
- R1: While idle, every lower-plate code is reference (`01`) and the sample switch is open. For `SAMPLE_CYC` cycles after an accepted strobe, every plate stays at reference and the sample switch is closed.
- R2: A comparator high in the sign cycle means positive (word bit 7 = 1). All plates then go to ground (`11`) and the sample switch stays closed. A comparator low means negative (bit 7 = 0): the plates stay at reference (`01`) and the switch opens.
- R3: The chord search starts with capacitor 0 moved to the opposite position in the same cycle as the sign decision. It then moves one more capacitor per cycle, in increasing index, while the input is beyond. The chord is the index of the capacitor whose move flipped the comparator, or 7 if moving capacitors 0 to 6 never flips it.
- R4: During the step search, capacitors below the chord stay moved, the chord capacitor's plate takes the tap code (`10`), capacitors above the chord stay unmoved, and no plate code is `00`.
- R5: The step is found MSB first over 4 trials. The tap select equals twice the trial value, plus one when the chord is 0. The first trial therefore presents tap 16 (or 17 in chord 0). At most one plate carries the tap code.
- R6: The output word is {sign[7], chord[6:4], step[3:0]}. It changes only in the cycle the done pulse is high and holds until the next one.
- R7: Done is a one-cycle pulse with busy low. It appears `SAMPLE_CYC + 5 + n` clock edges after the edge that accepts the strobe, where n is chord+1 for chords 0 to 6 and 7 for chord 7.
- R8: Busy rises on the accepting edge and falls only with done. A strobe that arrives while busy is ignored and causes no extra conversion or done.
- R9: After reset the block is idle: no done, a zero word, the sample switch open, and all plates at reference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frameStrobe | input | 1 | Frame strobe; starts a conversion when idle |
| cmpHigh | input | 1 | Comparator output (top-plate node above zero) |
| plateSel | output | 2*NCAP | Lower-plate code per capacitor, capacitor i at bits [2i+1:2i] |
| sampleClosed | output | 1 | Sample switch closed |
| tapSel | output | TAP_W | Resistor-string tap index for the chord capacitor |
| busy | output | 1 | Conversion in progress |
| codeWord | output | WORD_W | Last sign/chord/step result |
| codeValid | output | 1 | One-cycle done pulse |

## Verification
On every cycle, the checker enforces the following: a legal plate code on each capacitor, at most one plate on the tap, a reference-only array with the switch open while idle, a single-cycle done that coincides with the end of busy, and a word that moves only with done. The values themselves can only be shown by the bench's scenarios. These are the polarity-dependent plate patterns after the sign decision and at the start of the step search, the half-step tap offset in chord 0, the chord-dependent latency, the ignored mid-conversion strobe, and whether each word matches a behavioural comparator model across the full input range, including both chord-7 extremes and the zero and minus-one codes.

// File: rtl/cenc_pkg.sv
package cenc_pkg;
  typedef enum logic [1:0] {
    PL_NONE = 2'b00,
    PL_REF  = 2'b01,
    PL_TAP  = 2'b10,
    PL_GND  = 2'b11
  } plate_e;

  typedef struct packed {
    logic startSample;
    logic signDecide;
    logic chordStep;
    logic sarStep;
  } seq_cmd_t;
endpackage

// File: rtl/cenc_ctrl.sv
module cenc_ctrl
  import cenc_pkg::*;
#(
  parameter int SAMPLE_CYC = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     frameStrobe,
  input  logic     beyond,
  input  logic     chordLast,
  input  logic     sarLast,
  output seq_cmd_t cmd,
  output logic     busy
);
  localparam int CNT_W = (SAMPLE_CYC > 1) ? $clog2(SAMPLE_CYC) : 1;

  typedef enum logic [2:0] {S_IDLE, S_SAMPLE, S_SIGN, S_CHORD, S_SAR} seq_state_e;

  seq_state_e state, stateNxt;
  logic [CNT_W-1:0] sampleCnt;

  always_comb begin
    cmd      = '0;
    stateNxt = state;
    case (state)
      S_IDLE: begin
        if (frameStrobe) begin
          cmd.startSample = 1'b1;
          stateNxt        = S_SAMPLE;
        end
      end
      S_SAMPLE: begin
        if (sampleCnt == CNT_W'(SAMPLE_CYC - 1)) stateNxt = S_SIGN;
      end
      S_SIGN: begin
        cmd.signDecide = 1'b1;
        stateNxt       = S_CHORD;
      end
      S_CHORD: begin
        cmd.chordStep = 1'b1;
        if (!beyond || chordLast) stateNxt = S_SAR;
      end
      S_SAR: begin
        cmd.sarStep = 1'b1;
        if (sarLast) stateNxt = S_IDLE;
      end
      default: stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      sampleCnt <= '0;
    end else begin
      state <= stateNxt;
      if (state == S_SAMPLE) sampleCnt <= sampleCnt + 1'b1;
      else                   sampleCnt <= '0;
    end
  end

  assign busy = (state != S_IDLE);
endmodule

// File: rtl/cenc_dpath.sv
module cenc_dpath
  import cenc_pkg::*;
#(
  parameter int CHORD_W = 3,
  parameter int STEP_W  = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  seq_cmd_t                   cmd,
  input  logic                       cmpHigh,
  output logic                       beyond,
  output logic                       chordLast,
  output logic                       sarLast,
  output logic [2*(1<<CHORD_W)-1:0]  plateSel,
  output logic                       sampleClosed,
  output logic [STEP_W:0]            tapSel,
  output logic [CHORD_W+STEP_W:0]    codeWord,
  output logic                       codeValid
);
  localparam int NCAP   = 1 << CHORD_W;
  localparam int WORD_W = 1 + CHORD_W + STEP_W;
  localparam int BIT_W  = (STEP_W > 1) ? $clog2(STEP_W) : 1;

  plate_e              plate [NCAP];
  logic                isPos;
  logic [CHORD_W-1:0]  idx;
  logic [CHORD_W-1:0]  chordSel;
  logic [CHORD_W-1:0]  chordFinal;
  logic [STEP_W-1:0]   trial;
  logic [STEP_W-1:0]   trialKept;
  logic [BIT_W-1:0]    bitPos;
  logic                sampleSw;
  logic [WORD_W-1:0]   word;
  logic                done;
  plate_e              swCode;

  // comparator read relative to polarity
  assign beyond    = (cmpHigh == isPos);
  assign chordLast = (idx == CHORD_W'(NCAP - 2));
  assign sarLast   = (bitPos == '0);
  assign swCode    = isPos ? PL_REF : PL_GND;
  assign chordFinal = beyond ? {CHORD_W{1'b1}} : idx;

  always_comb begin
    trialKept = trial;
    if (!beyond) trialKept[bitPos] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NCAP; i++) plate[i] <= PL_REF;
      isPos    <= 1'b0;
      idx      <= '0;
      chordSel <= '0;
      trial    <= '0;
      bitPos   <= '0;
      sampleSw <= 1'b0;
      word     <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (cmd.startSample) begin
        sampleSw <= 1'b1;
        for (int i = 0; i < NCAP; i++) plate[i] <= PL_REF;
      end
      if (cmd.signDecide) begin
        isPos    <= cmpHigh;
        sampleSw <= cmpHigh;
        idx      <= '0;
        for (int i = 0; i < NCAP; i++) begin
          if (i == 0) plate[i] <= cmpHigh ? PL_REF : PL_GND;
          else        plate[i] <= cmpHigh ? PL_GND : PL_REF;
        end
      end
      if (cmd.chordStep) begin
        if (beyond && !chordLast) begin
          idx                  <= idx + 1'b1;
          plate[idx + 1'b1]    <= swCode;
        end else begin
          plate[chordFinal] <= PL_TAP;
          chordSel          <= chordFinal;
          trial             <= STEP_W'(1) << (STEP_W - 1);
          bitPos            <= BIT_W'(STEP_W - 1);
        end
      end
      if (cmd.sarStep) begin
        if (!sarLast) begin
          trial  <= trialKept | (STEP_W'(1) << (bitPos - BIT_W'(1)));
          bitPos <= bitPos - BIT_W'(1);
        end else begin
          trial    <= trialKept;
          word     <= {isPos, chordSel, trialKept};
          done     <= 1'b1;
          sampleSw <= 1'b0;
          for (int i = 0; i < NCAP; i++) plate[i] <= PL_REF;
        end
      end
    end
  end

  for (genvar g = 0; g < NCAP; g++) begin : g_plate_out
    assign plateSel[2*g +: 2] = plate[g];
  end

  // half-step offset next to the origin
  assign tapSel       = {trial, (chordSel == '0)};
  assign sampleClosed = sampleSw;
  assign codeWord     = word;
  assign codeValid    = done;
endmodule

// File: rtl/compand_enc_seq.sv
module compand_enc_seq
  import cenc_pkg::*;
#(
  parameter int CHORD_W    = 3,
  parameter int STEP_W     = 4,
  parameter int SAMPLE_CYC = 2,
  localparam int NCAP      = 1 << CHORD_W,
  localparam int TAP_W     = STEP_W + 1,
  localparam int WORD_W    = 1 + CHORD_W + STEP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frameStrobe,
  input  logic              cmpHigh,
  output logic [2*NCAP-1:0] plateSel,
  output logic              sampleClosed,
  output logic [TAP_W-1:0]  tapSel,
  output logic              busy,
  output logic [WORD_W-1:0] codeWord,
  output logic              codeValid
);
  seq_cmd_t cmd;
  logic     beyond;
  logic     chordLast;
  logic     sarLast;

  cenc_ctrl #(.SAMPLE_CYC(SAMPLE_CYC)) ctrl_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .frameStrobe (frameStrobe),
    .beyond      (beyond),
    .chordLast   (chordLast),
    .sarLast     (sarLast),
    .cmd         (cmd),
    .busy        (busy)
  );

  cenc_dpath #(.CHORD_W(CHORD_W), .STEP_W(STEP_W)) dpath_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd          (cmd),
    .cmpHigh      (cmpHigh),
    .beyond       (beyond),
    .chordLast    (chordLast),
    .sarLast      (sarLast),
    .plateSel     (plateSel),
    .sampleClosed (sampleClosed),
    .tapSel       (tapSel),
    .codeWord     (codeWord),
    .codeValid    (codeValid)
  );
endmodule

// File: rtl/cenc_checker.sv
module cenc_checker #(
  parameter int NCAP   = 8,
  parameter int WORD_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2*NCAP-1:0] plateSel,
  input logic              sampleClosed,
  input logic              busy,
  input logic [WORD_W-1:0] codeWord,
  input logic              codeValid
);
  logic [NCAP-1:0] tapMask;
  logic [NCAP-1:0] refMask;
  logic [NCAP-1:0] nullMask;

  for (genvar g = 0; g < NCAP; g++) begin : g_mask
    assign tapMask[g]  = (plateSel[2*g +: 2] == 2'b10);
    assign refMask[g]  = (plateSel[2*g +: 2] == 2'b01);
    assign nullMask[g] = (plateSel[2*g +: 2] == 2'b00);
  end

  p_tap_unique_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tapMask));

  p_plate_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    nullMask == '0);

  p_idle_ref_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (&refMask && !sampleClosed));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    codeValid |=> !codeValid);

  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    codeValid |-> !busy);

  p_word_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !codeValid |-> $stable(codeWord));

  p_busy_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> codeValid);
endmodule

bind compand_enc_seq cenc_checker #(.NCAP(NCAP), .WORD_W(WORD_W)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .plateSel     (plateSel),
  .sampleClosed (sampleClosed),
  .busy         (busy),
  .codeWord     (codeWord),
  .codeValid    (codeValid)
);

// File: tb/compand_enc_seq_tb_top.sv
module compand_enc_seq_tb_top;
  localparam int CHORD_W    = 3;
  localparam int STEP_W     = 4;
  localparam int SAMPLE_CYC = 2;
  localparam int NCAP       = 1 << CHORD_W;
  localparam int TAP_W      = STEP_W + 1;
  localparam int WORD_W     = 1 + CHORD_W + STEP_W;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic              rst_n;
  logic              frameStrobe;
  logic              cmpHigh;
  logic [2*NCAP-1:0] plateSel;
  logic              sampleClosed;
  logic [TAP_W-1:0]  tapSel;
  logic              busy;
  logic [WORD_W-1:0] codeWord;
  logic              codeValid;

  int sigIn = 0;
  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;
  logic [WORD_W-1:0] expQ[$];

  compand_enc_seq #(.CHORD_W(CHORD_W), .STEP_W(STEP_W), .SAMPLE_CYC(SAMPLE_CYC)) dut_i (
    .clk(clk), .rst_n(rst_n), .frameStrobe(frameStrobe), .cmpHigh(cmpHigh),
    .plateSel(plateSel), .sampleClosed(sampleClosed), .tapSel(tapSel),
    .busy(busy), .codeWord(codeWord), .codeValid(codeValid)
  );

  function automatic int wOf(int i);
    return (i == 0) ? 1 : (1 << (i - 1));
  endfunction

  function automatic int bOf(int k);
    return (k == 0) ? 0 : (1 << (k - 1));
  endfunction

  // behavioural comparator: magnitude in 1/32 units of the smallest capacitor
  always_comb begin : cmp_model
    int mag;
    int thr;
    logic pos;
    logic allRef;
    logic [1:0] pc;
    pos    = (sigIn >= 0);
    mag    = pos ? sigIn : -sigIn;
    thr    = 0;
    allRef = 1'b1;
    for (int i = 0; i < NCAP; i++) begin
      pc = plateSel[2*i +: 2];
      if (pc != 2'b01) allRef = 1'b0;
      if (pc == 2'b10) thr = thr + wOf(i) * int'(tapSel);
      else if (pc == (pos ? 2'b01 : 2'b11)) thr = thr + wOf(i) * 32;
    end
    if (allRef) cmpHigh = pos;
    else        cmpHigh = pos ? (mag >= thr) : (mag < thr);
  end

  function automatic logic [WORD_W-1:0] expWord(int x);
    int mag;
    int c;
    int v;
    logic pos;
    pos = (x >= 0);
    mag = pos ? x : -x;
    c = 0;
    for (int k = 1; k < NCAP; k++) if (mag >= 32 * bOf(k)) c = k;
    v = 0;
    for (int s = 0; s < 16; s++)
      if (mag >= 32 * bOf(c) + wOf(c) * (2 * s + ((c == 0) ? 1 : 0))) v = s;
    return {pos, CHORD_W'(c), STEP_W'(v)};
  endfunction

  task automatic chk(string req, bit ok, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    logic [WORD_W-1:0] e;
    if (rst_n === 1'b1 && codeValid === 1'b1) begin
      if (expQ.size() == 0) begin
        chk("R8 done without accepted strobe", 1'b0, int'(codeWord), -1);
      end else begin
        e = expQ.pop_front();
        chk("R6 R3 R5 word", codeWord == e, int'(codeWord), int'(e));
      end
    end
  end

  task automatic runConv(int x, bit phase, bit poke);
    logic [WORD_W-1:0] e;
    logic [2*NCAP-1:0] expPl;
    logic [1:0] swc;
    logic [1:0] unsw;
    int c;
    int nc;
    int lat;
    int n;
    bit pos;
    e    = expWord(x);
    c    = int'(e[WORD_W-2 -: CHORD_W]);
    pos  = (x >= 0);
    nc   = (c < NCAP - 1) ? c + 1 : NCAP - 1;
    lat  = SAMPLE_CYC + 5 + nc;
    swc  = pos ? 2'b01 : 2'b11;
    unsw = pos ? 2'b11 : 2'b01;
    @(negedge clk);
    sigIn = x;
    frameStrobe = 1'b1;
    expQ.push_back(e);
    @(negedge clk);
    frameStrobe = 1'b0;
    n = 0;
    if (phase) begin
      chk("R1 sampling plates", plateSel == {NCAP{2'b01}}, int'(plateSel), int'({NCAP{2'b01}}));
      chk("R1 sample switch closed", sampleClosed == 1'b1, int'(sampleClosed), 1);
      chk("R8 busy on accept", busy == 1'b1, int'(busy), 1);
    end
    while (!codeValid && n < 100) begin
      @(negedge clk);
      n++;
      if (poke && n == 3) frameStrobe = 1'b1;
      if (poke && n == 4) frameStrobe = 1'b0;
      if (phase && n == SAMPLE_CYC + 1) begin
        expPl = {NCAP{unsw}};
        expPl[1:0] = swc;
        chk("R2 R3 plates after sign", plateSel == expPl, int'(plateSel), int'(expPl));
        chk("R2 switch after sign", sampleClosed == pos, int'(sampleClosed), int'(pos));
      end
      if (phase && n == SAMPLE_CYC + 1 + nc) begin
        for (int i = 0; i < NCAP; i++)
          expPl[2*i +: 2] = (i < c) ? swc : ((i == c) ? 2'b10 : unsw);
        chk("R4 plates in step search", plateSel == expPl, int'(plateSel), int'(expPl));
        chk("R5 first tap", int'(tapSel) == 16 + ((c == 0) ? 1 : 0), int'(tapSel), 16 + ((c == 0) ? 1 : 0));
      end
    end
    chk("R7 latency", n == lat, n, lat);
    if (poke) begin
      repeat (4) @(negedge clk);
      chk("R8 idle after ignored strobe", busy == 1'b0, int'(busy), 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    frameStrobe = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 reset done", codeValid == 1'b0, int'(codeValid), 0);
    chk("R9 reset busy", busy == 1'b0, int'(busy), 0);
    chk("R9 reset word", codeWord == '0, int'(codeWord), 0);
    chk("R9 reset plates", plateSel == {NCAP{2'b01}}, int'(plateSel), int'({NCAP{2'b01}}));
    chk("R9 reset switch", sampleClosed == 1'b0, int'(sampleClosed), 0);
    rst_n = 1'b1;
    @(negedge clk);

    runConv(0, 1, 0);       // R5 half-step: zero stays at step 0
    runConv(-1, 1, 0);
    runConv(4095, 1, 0);    // R3 chord 7 positive
    runConv(-4095, 1, 0);   // R3 chord 7 negative
    runConv(32, 1, 0);
    runConv(-31, 1, 0);
    runConv(2047, 1, 0);
    runConv(-2048, 1, 0);
    runConv(700, 1, 1);     // R8 strobe during conversion
    runConv(-150, 0, 1);
    for (int x = -4095; x <= 4095; x += 91) runConv(x, 0, 0);

    repeat (5) @(negedge clk);
    chk("R8 all results seen", expQ.size() == 0, expQ.size(), 0);
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule